// File: doc/BRIEF.md
# Outbound Address Translation Viewport Unit

This unit turns CPU-side request addresses into bus addresses for outbound traffic of a PCIe root complex. It holds a parameterised number of translation windows. Each window has a 64-bit start address, a 32-bit low word for its last address (the high word is shared with the start address), a 64-bit destination address, a transaction-kind code and an enable bit. When a request address falls inside an enabled window, the unit adds the request's distance from the window start to the window's destination, and reports the window's kind. For configuration kinds it also splits the bus, device and function numbers out of the destination's low word.

Software never addresses a window directly. A single selector register names one window and a direction, and the seven per-window registers that follow it in the register space always act on the window the selector names. The same compare logic can therefore point a window at memory, I/O or configuration space just by rewriting its kind code. Request lookups and register reads each return their result one clock after they are presented.

Top module: `ob_xlate`

## Requirements
- R1: After synchronous reset, all windows are disabled with all fields zero, the selector reads 0, and `rsp_valid` and `csr_rdata` are 0.
- R2: Register reads return data one cycle after `csr_rd`. The selector at 0x900 reads back the direction in bit 31 and the index in bits 7:0. For the selected window: 0x904 returns the kind code in bits 2:0, 0x908 returns the enable in bit 31 and the stored match-mode flag in bit 30, and 0x90C, 0x910, 0x914, 0x918 and 0x91C return the start low word, start high word, last-address low word, destination low word and destination high word as written.
- R3: Writing to the per-window registers changes only the window named by the selector. Changing the selector leaves every stored window unchanged.
- R4: When the selector names the inbound direction (bit 31 = 1) or an index at or above the window count, writes to 0x904 to 0x91C change no window, and reads of those offsets return zero.
- R5: A request hits a window only when the window is enabled and start <= address <= {start high word, last-address low word}. Both boundaries are inside the window.
- R6: On a hit, the result address is the destination plus (address - start), computed over the full 64 bits with carry into the high word.
- R7: On a hit, `rsp_kind` is the window's kind code (0 memory, 2 I/O, 4 configuration type 0, 5 configuration type 1). For kinds 4 and 5, bus, device and function come from destination low word bits 31:24, 23:19 and 18:16. For every other kind they are zero.
- R8: When several enabled windows match, the window with the lowest index decides the result.
- R9: A request that hits no window returns `rsp_hit` = 0, the request address unchanged, kind 0 and zero bus, device and function.
- R10: A disabled window never produces a hit, even when the request address lies inside its range.
- R11: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. Back-to-back requests each get their own response in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | 12 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, valid the cycle after `csr_rd` |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 64 | CPU-side request address |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | A window matched |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_kind | output | 3 | Transaction kind code |
| rsp_bus | output | 8 | Bus number for configuration kinds |
| rsp_dev | output | 5 | Device number for configuration kinds |
| rsp_fn | output | 3 | Function number for configuration kinds |

## Verification
Lookups are driven at each window's first and last address and one step outside each end, which separates an inclusive compare from an exclusive one. Requests that differ only in bits above 31 show whether the start high word takes part in the upper bound. Two overlapping windows are probed first with both enabled and then with the lower one disabled, which separates index priority from the enable gating. A destination placed just below a 32-bit boundary exposes a lost carry in the 64-bit sum. Register traffic through valid, out-of-range and inbound selector values shows whether the indirect access reaches exactly one window or none.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;

  localparam int CSR_AW = 12;
  localparam int WORD_W = 32;
  localparam int KIND_W = 3;

  localparam logic [CSR_AW-1:0] OFF_SEL   = 12'h900;
  localparam logic [CSR_AW-1:0] OFF_KIND  = 12'h904;
  localparam logic [CSR_AW-1:0] OFF_CTRL  = 12'h908;
  localparam logic [CSR_AW-1:0] OFF_BLO   = 12'h90C;
  localparam logic [CSR_AW-1:0] OFF_BHI   = 12'h910;
  localparam logic [CSR_AW-1:0] OFF_LAST  = 12'h914;
  localparam logic [CSR_AW-1:0] OFF_DLO   = 12'h918;
  localparam logic [CSR_AW-1:0] OFF_DHI   = 12'h91C;

  localparam logic [KIND_W-1:0] KIND_MEM  = 3'd0;
  localparam logic [KIND_W-1:0] KIND_IO   = 3'd2;
  localparam logic [KIND_W-1:0] KIND_CFG0 = 3'd4;
  localparam logic [KIND_W-1:0] KIND_CFG1 = 3'd5;

  // Fields the lookup path needs from one window
  typedef struct packed {
    logic              en;
    logic [KIND_W-1:0] kind;
    logic [63:0]       start;
    logic [31:0]       last_lo;
    logic [63:0]       dest;
  } win_t;

endpackage

// File: rtl/ob_xlate_regs.sv
module ob_xlate_regs
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int IDX_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      csr_wr,
  input  logic                      csr_rd,
  input  logic [CSR_AW-1:0]         csr_addr,
  input  logic [WORD_W-1:0]         csr_wdata,
  output logic [WORD_W-1:0]         csr_rdata,
  output win_t [NUM_WIN-1:0]        wins_o
);

  localparam int PAD_W = WORD_W - 1 - IDX_W;

  logic             sel_dir;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_ok;
  logic [WORD_W-1:0] rd_words [NUM_WIN];
  logic [WORD_W-1:0] rd_val;

  assign sel_ok = !sel_dir && ({1'b0, sel_idx} < (IDX_W+1)'(NUM_WIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_dir <= 1'b0;
      sel_idx <= '0;
    end else if (csr_wr && csr_addr == OFF_SEL) begin
      sel_dir <= csr_wdata[WORD_W-1];
      sel_idx <= csr_wdata[IDX_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    win_t        w_q;
    logic        mode_q;
    logic        picked;
    logic [WORD_W-1:0] rd_g;

    assign picked = sel_ok && (sel_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        w_q    <= '0;
        mode_q <= 1'b0;
      end else if (csr_wr && picked) begin
        case (csr_addr)
          OFF_KIND: w_q.kind          <= csr_wdata[KIND_W-1:0];
          OFF_CTRL: begin
            w_q.en <= csr_wdata[31];
            mode_q <= csr_wdata[30];
          end
          OFF_BLO:  w_q.start[31:0]   <= csr_wdata;
          OFF_BHI:  w_q.start[63:32]  <= csr_wdata;
          OFF_LAST: w_q.last_lo       <= csr_wdata;
          OFF_DLO:  w_q.dest[31:0]    <= csr_wdata;
          OFF_DHI:  w_q.dest[63:32]   <= csr_wdata;
          default: ;
        endcase
      end
    end

    always_comb begin
      case (csr_addr)
        OFF_KIND: rd_g = {{(WORD_W-KIND_W){1'b0}}, w_q.kind};
        OFF_CTRL: rd_g = {w_q.en, mode_q, {(WORD_W-2){1'b0}}};
        OFF_BLO:  rd_g = w_q.start[31:0];
        OFF_BHI:  rd_g = w_q.start[63:32];
        OFF_LAST: rd_g = w_q.last_lo;
        OFF_DLO:  rd_g = w_q.dest[31:0];
        OFF_DHI:  rd_g = w_q.dest[63:32];
        default:  rd_g = '0;
      endcase
    end

    assign rd_words[g] = rd_g;
    assign wins_o[g]   = w_q;
  end

  always_comb begin
    rd_val = '0;
    if (csr_addr == OFF_SEL) begin
      rd_val = {sel_dir, {PAD_W{1'b0}}, sel_idx};
    end else if (sel_ok) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (sel_idx == IDX_W'(i)) rd_val = rd_words[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         csr_rdata <= '0;
    else if (csr_rd) csr_rdata <= rd_val;
  end

  // R4
  stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && !sel_ok) |=> $stable(wins_o));

  // R4
  stray_read_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_rd && !sel_ok && csr_addr != OFF_SEL) |=> (csr_rdata == '0));

endmodule

// File: rtl/ob_xlate_lookup.sv
module ob_xlate_lookup
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  win_t [NUM_WIN-1:0] wins,
  input  logic               req_valid,
  input  logic [63:0]        req_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [63:0]        rsp_addr,
  output logic [KIND_W-1:0]  rsp_kind,
  output logic [7:0]         rsp_bus,
  output logic [4:0]         rsp_dev,
  output logic [2:0]         rsp_fn
);

  localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [NUM_WIN-1:0] hit_vec;
  logic [NUM_WIN-1:0] en_vec;
  logic [SEL_W-1:0]   win_sel;
  win_t               w;
  logic [63:0]        xl_addr;
  logic               is_cfg;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    logic [63:0] top_addr;
    assign top_addr   = {wins[g].start[63:32], wins[g].last_lo};
    assign en_vec[g]  = wins[g].en;
    assign hit_vec[g] = wins[g].en && (req_addr >= wins[g].start) &&
                        (req_addr <= top_addr);
  end

  // lowest index has priority: scan downward so it is assigned last
  always_comb begin
    win_sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_sel = SEL_W'(i);
    end
  end

  assign w       = wins[win_sel];
  assign xl_addr = w.dest + (req_addr - w.start);
  assign is_cfg  = (w.kind == KIND_CFG0) || (w.kind == KIND_CFG1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
      rsp_kind  <= KIND_MEM;
      rsp_bus   <= '0;
      rsp_dev   <= '0;
      rsp_fn    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        if (|hit_vec) begin
          rsp_hit  <= 1'b1;
          rsp_addr <= xl_addr;
          rsp_kind <= w.kind;
          rsp_bus  <= is_cfg ? w.dest[31:24] : 8'd0;
          rsp_dev  <= is_cfg ? w.dest[23:19] : 5'd0;
          rsp_fn   <= is_cfg ? w.dest[18:16] : 3'd0;
        end else begin
          rsp_hit  <= 1'b0;
          rsp_addr <= req_addr;
          rsp_kind <= KIND_MEM;
          rsp_bus  <= '0;
          rsp_dev  <= '0;
          rsp_fn   <= '0;
        end
      end
    end
  end

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R11
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R9
  miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit_vec == '0) |=> (!rsp_hit && rsp_addr == $past(req_addr)));

  // R10
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && en_vec == '0) |=> !rsp_hit);

  // R7
  plain_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind != KIND_CFG0 && rsp_kind != KIND_CFG1)
      |-> (rsp_bus == '0 && rsp_dev == '0 && rsp_fn == '0));

endmodule

// File: rtl/ob_xlate.sv
module ob_xlate
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int IDX_W   = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         csr_wr,
  input  logic         csr_rd,
  input  logic [11:0]  csr_addr,
  input  logic [31:0]  csr_wdata,
  output logic [31:0]  csr_rdata,
  input  logic         req_valid,
  input  logic [63:0]  req_addr,
  output logic         rsp_valid,
  output logic         rsp_hit,
  output logic [63:0]  rsp_addr,
  output logic [2:0]   rsp_kind,
  output logic [7:0]   rsp_bus,
  output logic [4:0]   rsp_dev,
  output logic [2:0]   rsp_fn
);

  win_t [NUM_WIN-1:0] wins;

  ob_xlate_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .csr_wr    (csr_wr),
    .csr_rd    (csr_rd),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .wins_o    (wins)
  );

  ob_xlate_lookup #(.NUM_WIN(NUM_WIN)) u_lookup (
    .clk       (clk),
    .rst       (rst),
    .wins      (wins),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_addr  (rsp_addr),
    .rsp_kind  (rsp_kind),
    .rsp_bus   (rsp_bus),
    .rsp_dev   (rsp_dev),
    .rsp_fn    (rsp_fn)
  );

endmodule

// File: tb/ob_xlate_bench.sv
`timescale 1ns/1ps
module ob_xlate_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr = 1'b0;
  logic        csr_rd = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [63:0] rsp_addr;
  logic [2:0]  rsp_kind;
  logic [7:0]  rsp_bus;
  logic [4:0]  rsp_dev;
  logic [2:0]  rsp_fn;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct packed {
    logic        hit;
    logic [63:0] addr;
    logic [2:0]  kind;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  ob_xlate u_ob_xlate (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
    .rsp_bus(rsp_bus), .rsp_dev(rsp_dev), .rsp_fn(rsp_fn)
  );

  function automatic exp_t e_miss(input logic [63:0] a);
    return {1'b0, a, 3'd0, 8'd0, 5'd0, 3'd0};
  endfunction

  function automatic exp_t e_hit(input logic [63:0] a, input logic [2:0] k,
                                 input logic [7:0] b, input logic [4:0] d,
                                 input logic [2:0] f);
    return {1'b1, a, k, b, d, f};
  endfunction

  task automatic put(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_rd = 1'b0;
    n_vec++;
    if (csr_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: reg 0x%03h got 0x%08h expected 0x%08h", tag, a, csr_rdata, exp);
    end
  endtask

  // driver: one request per call, held only for that cycle unless another follows
  task automatic drive(input logic [63:0] a, input exp_t e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compare each response against the oldest expectation
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      exp_t  got;
      exp_t  want;
      string t;
      got = {rsp_hit, rsp_addr, rsp_kind, rsp_bus, rsp_dev, rsp_fn};
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11: unexpected response got %h expected none", got);
      end else begin
        want = exp_q.pop_front();
        t    = tag_q.pop_front();
        if (got !== want) begin
          n_bad++;
          $display("FAIL %s: got hit=%b addr=%h kind=%0d b/d/f=%h/%h/%h expected hit=%b addr=%h kind=%0d b/d/f=%h/%h/%h",
                   t, got.hit, got.addr, got.kind, got.bus, got.dev, got.fn,
                   want.hit, want.addr, want.kind, want.bus, want.dev, want.fn);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    n_vec++;
    if (rsp_valid !== 1'b0 || csr_rdata !== 32'h0) begin
      n_bad++;
      $display("FAIL R1: rsp_valid=%b rdata=%h expected 0/0", rsp_valid, csr_rdata);
    end
    peek(12'h900, 32'h0, "R1");
    peek(12'h908, 32'h0, "R1");

    // window 0: memory, 0x1000_0000..0x1000_FFFF -> 0x1_8000_0000
    put(12'h900, 32'h0);
    put(12'h904, 32'd0);
    put(12'h90C, 32'h1000_0000);
    put(12'h910, 32'h0);
    put(12'h914, 32'h1000_FFFF);
    put(12'h918, 32'h8000_0000);
    put(12'h91C, 32'h1);
    put(12'h908, 32'h8000_0000);

    // window 1: config type 0, bus 0x12 dev 0x1B fn 5
    put(12'h900, 32'h1);
    put(12'h904, 32'd4);
    put(12'h90C, 32'h2000_0000);
    put(12'h910, 32'h0);
    put(12'h914, 32'h2000_0FFF);
    put(12'h918, 32'h12DD_0000);
    put(12'h91C, 32'h0);
    put(12'h908, 32'hC000_0000);

    // R2 readback of window 1
    peek(12'h900, 32'h1, "R2");
    peek(12'h904, 32'd4, "R2");
    peek(12'h908, 32'hC000_0000, "R2");
    peek(12'h90C, 32'h2000_0000, "R2");
    peek(12'h914, 32'h2000_0FFF, "R2");
    peek(12'h918, 32'h12DD_0000, "R2");

    // R3 window 0 kept its own values
    put(12'h900, 32'h0);
    peek(12'h90C, 32'h1000_0000, "R3");
    peek(12'h91C, 32'h1, "R3");
    peek(12'h904, 32'd0, "R3");

    // R4 out-of-range index and inbound direction
    put(12'h900, 32'h2);
    put(12'h90C, 32'h0000_DEAD);
    peek(12'h90C, 32'h0, "R4");
    peek(12'h900, 32'h2, "R4");
    put(12'h900, 32'h8000_0000);
    put(12'h914, 32'h0);
    peek(12'h914, 32'h0, "R4");
    peek(12'h900, 32'h8000_0000, "R4");
    put(12'h900, 32'h0);
    peek(12'h914, 32'h1000_FFFF, "R4");
    peek(12'h90C, 32'h1000_0000, "R4");
    put(12'h900, 32'h1);
    peek(12'h90C, 32'h2000_0000, "R4");

    // R5 R6 R9 R11 boundaries, back to back
    drive(64'h0000_0000_1000_0000, e_hit(64'h1_8000_0000, 3'd0, 8'd0, 5'd0, 3'd0), "R5 start");
    drive(64'h0000_0000_1000_FFFF, e_hit(64'h1_8000_FFFF, 3'd0, 8'd0, 5'd0, 3'd0), "R5 last");
    drive(64'h0000_0000_0FFF_FFFF, e_miss(64'h0000_0000_0FFF_FFFF), "R5 R9 below");
    drive(64'h0000_0000_1001_0000, e_miss(64'h0000_0000_1001_0000), "R5 R9 above");
    drive(64'h0000_0001_1000_0000, e_miss(64'h0000_0001_1000_0000), "R5 high word");
    drive(64'h0000_0000_2000_0ABC, e_hit(64'h0000_0000_12DD_0ABC, 3'd4, 8'h12, 5'h1B, 3'd5), "R6 R7 cfg0");
    idle();
    idle();

    // R8 overlap: window 1 moved onto window 0, kind config type 1
    put(12'h900, 32'h1);
    put(12'h90C, 32'h1000_0000);
    put(12'h914, 32'h1000_0FFF);
    put(12'h904, 32'd5);
    drive(64'h0000_0000_1000_0010, e_hit(64'h1_8000_0010, 3'd0, 8'd0, 5'd0, 3'd0), "R8 lowest wins");
    idle();

    // R10 disable window 0 -> window 1 takes it
    put(12'h900, 32'h0);
    put(12'h908, 32'h0);
    drive(64'h0000_0000_1000_0010, e_hit(64'h0000_0000_12DD_0010, 3'd5, 8'h12, 5'h1B, 3'd5), "R10 R8 R7 cfg1");
    idle();

    // R10 both disabled -> miss
    put(12'h900, 32'h1);
    put(12'h908, 32'h0);
    drive(64'h0000_0000_1000_0010, e_miss(64'h0000_0000_1000_0010), "R10 R9 all off");
    idle();

    // R6 carry into high word, I/O kind gives zero b/d/f
    put(12'h900, 32'h0);
    put(12'h918, 32'hFFFF_FFF0);
    put(12'h91C, 32'h2);
    put(12'h904, 32'd2);
    put(12'h908, 32'h8000_0000);
    drive(64'h0000_0000_1000_0020, e_hit(64'h3_0000_0010, 3'd2, 8'd0, 5'd0, 3'd0), "R6 R7 carry io");
    idle();

    // R5 start high word forms the top of the upper bound
    put(12'h910, 32'h1);
    drive(64'h0000_0001_1000_0005, e_hit(64'h2_FFFF_FFF5, 3'd2, 8'd0, 5'd0, 3'd0), "R5 high hit");
    drive(64'h0000_0000_1000_0005, e_miss(64'h0000_0000_1000_0005), "R5 R9 high miss");
    idle();
    idle();

    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11: %0d responses missing expected 0", exp_q.size());
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule